// File: doc/BRIEF.md
# Multi-Highway Time-Slot Interchanger

This block switches byte-wide channels between a set of serial receive TDM highways and the same number of serial transmit TDM highways. One clock and one frame-sync pulse time every highway. Each frame holds a fixed number of byte slots per highway, and each slot is eight clock cycles with the most significant bit first. Every received byte is stored in a double-buffered data store, addressed by highway and slot.

During the next frame, a connection store rebuilds each output slot. The connection store has one entry per output highway and slot. Each entry names the source highway and source slot, and holds an enable bit that drives the highway's output-enable pin. When a slot is disabled, the serial output rests at 1. A small host port reads and writes both stores.

At the default size there are 16 highways of 64 slots, which gives 1024 channels. Both counts are parameters, so a smaller instance can be built for simulation.

Top module: `tsi_core`

## Requirements
- R1: After reset, and until the first cycle with `fsync` high, every `txoe` bit is 0 and every `txd` bit is 1. An asynchronous reset returns the outputs to this state at once.
- R2: The cycle in which `fsync` is high is bit 0 of slot 0. Each slot lasts 8 cycles and carries its byte most significant bit first, on input and output alike. A frame lasts SLOTS*8 cycles, and the count wraps by itself when no new `fsync` arrives.
- R3: Bytes received in frame F appear on the outputs in frame F+1. The write page of the data store swaps at the last cycle of each frame, and frame 0 after reset writes page 0.
- R4: Output slot s of highway h carries the byte named by the connection entry at index h*SLOTS+s. The entry layout is: the enable at bit HW+SW, the source highway at bits [HW+SW-1:SW], and the source slot at bits [SW-1:0], where HW=log2(NUM_HWY) and SW=log2(SLOTS). The first bit of that byte is on `txd` in the first cycle of the slot.
- R5: When an entry for output slot 0 names the last slot of a source highway, the byte that completes at that same frame boundary is delivered without waiting for the data-store write.
- R6: An entry with the enable clear holds `txoe` at 0 and `txd` at 1 for the whole slot. An entry with the enable set holds `txoe` at 1 for the whole slot.
- R7: `txoe` changes only on a slot boundary.
- R8: When `host_sel`=0 the host port addresses the data store at {page (MSB), highway, slot} and uses the low 8 bits of write data. When `host_sel`=1 it addresses the connection store at the low HW+SW address bits. Read data is zero-extended and is valid in the cycle after a `host_en` cycle with `host_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all highways |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, high in bit 0 of slot 0 |
| rxd | input | NUM_HWY | Serial receive data, one bit per highway |
| txd | output | NUM_HWY | Serial transmit data, one bit per highway |
| txoe | output | NUM_HWY | Per-highway output enable for the current slot |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_sel | input | 1 | 0 selects the data store, 1 selects the connection store |
| host_addr | input | 1+HW+SW | Host word address |
| host_wdata | input | max(8, HW+SW+1) | Host write data |
| host_rdata | output | max(8, HW+SW+1) | Registered host read data |

## Verification
A corrupt connection entry or a wrong page select shows up within one slot: that output carries a byte from the wrong channel or the wrong frame, or its enable is wrong for all eight bits. A page counter that is out of step with the frame shows up as data that is one frame too old or too new. A missing forward path corrupts only slot 0 of outputs whose source is the last slot. The bench therefore checks every output slot of three full frames against a map that includes this case, and checks the host view of the stored page afterwards.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   typedef enum logic {SEL_DATA = 1'b0, SEL_CONN = 1'b1} host_sel_e;
   localparam int BYTE_W = 8;
endpackage

// File: rtl/tsi_timing.sv
// Frame position counter: the fsync cycle is position 0; holds until first sync.
module tsi_timing #(
   parameter int SLOTS = 64,
   localparam int SW = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fsync,
   output logic          live,
   output logic [2:0]    bit_pos,
   output logic [SW-1:0] slot_pos,
   output logic [SW-1:0] next_slot,
   output logic          byte_end,
   output logic          frame_end
);
   localparam int PW = SW + 3;

   logic [PW-1:0] pos_q;
   logic [PW-1:0] cur_pos;
   logic          live_q;
   logic          active;

   assign active  = live_q | fsync;
   assign cur_pos = fsync ? '0 : pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         live_q <= 1'b0;
      end else if (active) begin
         pos_q  <= cur_pos + 1'b1;
         live_q <= 1'b1;
      end
   end

   assign live      = live_q;
   assign bit_pos   = cur_pos[2:0];
   assign slot_pos  = cur_pos[PW-1:3];
   assign next_slot = slot_pos + 1'b1;
   assign byte_end  = active && (bit_pos == 3'd7);
   assign frame_end = byte_end && (slot_pos == SW'(SLOTS - 1));
endmodule

// File: rtl/tsi_rx_lane.sv
// Serial-to-byte assembly for one receive highway, MSB first.
module tsi_rx_lane (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   output logic [7:0] rx_byte
);
   logic [6:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[5:0], rxd};
   end

   assign rx_byte = {sh_q, rxd};
endmodule

// File: rtl/tsi_tx_lane.sv
// Byte-to-serial for one transmit highway; idles at 1 when not enabled.
module tsi_tx_lane (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic       load_en,
   input  logic [7:0] load_byte,
   output logic       txd,
   output logic       txoe
);
   logic [7:0] sh_q;
   logic       oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= 8'hFF;
         oe_q <= 1'b0;
      end else if (load) begin
         sh_q <= load_byte;
         oe_q <= load_en;
      end else begin
         sh_q <= {sh_q[6:0], 1'b1};
      end
   end

   assign txd  = oe_q ? sh_q[7] : 1'b1;
   assign txoe = oe_q;
endmodule

// File: rtl/tsi_data_store.sv
// Two pages of NUM_HWY*SLOTS bytes; receive writes the current page, swapping each frame.
module tsi_data_store #(
   parameter int NUM_HWY = 16,
   parameter int SLOTS   = 64,
   localparam int HW = $clog2(NUM_HWY),
   localparam int SW = $clog2(SLOTS),
   localparam int AW = 1 + HW + SW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          byte_end,
   input  logic          frame_end,
   input  logic [SW-1:0] wr_slot,
   input  logic [7:0]    rx_byte [NUM_HWY],
   input  logic [AW-1:0] rd_addr [NUM_HWY],
   output logic [7:0]    rd_data [NUM_HWY],
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata,
   output logic          wr_page
);
   localparam int DEPTH = 2 * NUM_HWY * SLOTS;

   logic [7:0] mem [DEPTH];
   logic       page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         page_q <= 1'b0;
      else if (frame_end) page_q <= ~page_q;
   end

   // Host write first so that a receive write to the same cell wins.
   always_ff @(posedge clk) begin
      if (host_we) mem[host_addr] <= host_wdata;
      if (byte_end) begin
         for (int h = 0; h < NUM_HWY; h++) begin
            mem[{page_q, HW'(h), wr_slot}] <= rx_byte[h];
         end
      end
   end

   for (genvar g = 0; g < NUM_HWY; g++) begin : g_rd
      assign rd_data[g] = mem[rd_addr[g]];
   end

   assign host_rdata = mem[host_addr];
   assign wr_page    = page_q;
endmodule

// File: rtl/tsi_conn_store.sv
// One entry per output highway and slot: {enable, source highway, source slot}.
module tsi_conn_store #(
   parameter int NUM_HWY = 16,
   parameter int SLOTS   = 64,
   localparam int HW  = $clog2(NUM_HWY),
   localparam int SW  = $clog2(SLOTS),
   localparam int CAW = HW + SW,
   localparam int EW  = CAW + 1
) (
   input  logic           clk,
   input  logic [CAW-1:0] rd_addr [NUM_HWY],
   output logic [EW-1:0]  rd_entry [NUM_HWY],
   input  logic           host_we,
   input  logic [CAW-1:0] host_addr,
   input  logic [EW-1:0]  host_wdata,
   output logic [EW-1:0]  host_rdata
);
   localparam int DEPTH = NUM_HWY * SLOTS;

   logic [EW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (host_we) mem[host_addr] <= host_wdata;
   end

   for (genvar g = 0; g < NUM_HWY; g++) begin : g_rd
      assign rd_entry[g] = mem[rd_addr[g]];
   end

   assign host_rdata = mem[host_addr];
endmodule

// File: rtl/tsi_core.sv
module tsi_core #(
   parameter int NUM_HWY = 16,
   parameter int SLOTS   = 64,
   localparam int HW  = $clog2(NUM_HWY),
   localparam int SW  = $clog2(SLOTS),
   localparam int CAW = HW + SW,
   localparam int EW  = CAW + 1,
   localparam int AW  = 1 + CAW,
   localparam int DW  = (EW > 8) ? EW : 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fsync,
   input  logic [NUM_HWY-1:0] rxd,
   output logic [NUM_HWY-1:0] txd,
   output logic [NUM_HWY-1:0] txoe,
   input  logic               host_en,
   input  logic               host_we,
   input  logic               host_sel,
   input  logic [AW-1:0]      host_addr,
   input  logic [DW-1:0]      host_wdata,
   output logic [DW-1:0]      host_rdata
);
   import tsi_pkg::*;

   if ((NUM_HWY < 2) || ((NUM_HWY & (NUM_HWY - 1)) != 0)) begin : g_bad_hwy
      $error("NUM_HWY must be a power of two and at least 2");
   end
   if ((SLOTS < 2) || ((SLOTS & (SLOTS - 1)) != 0)) begin : g_bad_slots
      $error("SLOTS must be a power of two and at least 2");
   end

   logic          live;
   logic [2:0]    bit_pos;
   logic [SW-1:0] slot_pos;
   logic [SW-1:0] next_slot;
   logic          byte_end;
   logic          frame_end;
   logic          wr_page;

   logic [7:0]     rx_byte  [NUM_HWY];
   logic [AW-1:0]  ds_addr  [NUM_HWY];
   logic [7:0]     ds_rd    [NUM_HWY];
   logic [CAW-1:0] cs_addr  [NUM_HWY];
   logic [EW-1:0]  cs_entry [NUM_HWY];
   logic [7:0]     ds_host_rd;
   logic [EW-1:0]  cs_host_rd;
   logic           host_conn;

   assign host_conn = (host_sel_e'(host_sel) == SEL_CONN);

   tsi_timing #(.SLOTS(SLOTS)) u_timing (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .live(live),
      .bit_pos(bit_pos), .slot_pos(slot_pos), .next_slot(next_slot),
      .byte_end(byte_end), .frame_end(frame_end)
   );

   tsi_data_store #(.NUM_HWY(NUM_HWY), .SLOTS(SLOTS)) u_data (
      .clk(clk), .rst_n(rst_n), .byte_end(byte_end), .frame_end(frame_end),
      .wr_slot(slot_pos), .rx_byte(rx_byte), .rd_addr(ds_addr), .rd_data(ds_rd),
      .host_we(host_en & host_we & ~host_conn), .host_addr(host_addr),
      .host_wdata(host_wdata[7:0]), .host_rdata(ds_host_rd), .wr_page(wr_page)
   );

   tsi_conn_store #(.NUM_HWY(NUM_HWY), .SLOTS(SLOTS)) u_conn (
      .clk(clk), .rd_addr(cs_addr), .rd_entry(cs_entry),
      .host_we(host_en & host_we & host_conn), .host_addr(host_addr[CAW-1:0]),
      .host_wdata(host_wdata[EW-1:0]), .host_rdata(cs_host_rd)
   );

   for (genvar g = 0; g < NUM_HWY; g++) begin : g_lane
      logic [HW-1:0] src_h;
      logic [SW-1:0] src_s;
      logic          src_en;
      logic          page_sel;
      logic          fwd;
      logic [7:0]    fetched;

      tsi_rx_lane u_rx (.clk(clk), .rst_n(rst_n), .rxd(rxd[g]), .rx_byte(rx_byte[g]));

      // Fetch the entry for the slot that starts after this byte boundary.
      assign cs_addr[g] = {HW'(g), next_slot};
      assign src_en     = cs_entry[g][EW-1];
      assign src_h      = cs_entry[g][CAW-1:SW];
      assign src_s      = cs_entry[g][SW-1:0];
      // Slot 0 of the next frame reads the page that is just finishing.
      assign page_sel   = frame_end ? wr_page : ~wr_page;
      assign ds_addr[g] = {page_sel, src_h, src_s};
      assign fwd        = frame_end && (src_s == SW'(SLOTS - 1));
      assign fetched    = fwd ? rx_byte[src_h] : ds_rd[g];

      tsi_tx_lane u_tx (
         .clk(clk), .rst_n(rst_n), .load(byte_end), .load_en(src_en),
         .load_byte(fetched), .txd(txd[g]), .txoe(txoe[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   host_rdata <= '0;
      else if (host_en && !host_we) host_rdata <= host_conn ? DW'(cs_host_rd) : DW'(ds_host_rd);
   end
endmodule

// File: rtl/tsi_core_checker.sv
module tsi_core_checker #(
   parameter int NUM_HWY = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               live,
   input logic [2:0]         bit_pos,
   input logic               frame_end,
   input logic               wr_page,
   input logic [NUM_HWY-1:0] txd,
   input logic [NUM_HWY-1:0] txoe
);
   assert_quiet_before_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !live |-> (txoe == '0));

   assert_page_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> (wr_page != $past(wr_page)));

   assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(wr_page));

   assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((~txoe & ~txd) == '0));

   assert_oe_slot_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_pos != 3'd7) |=> $stable(txoe));
endmodule

bind tsi_core tsi_core_checker #(.NUM_HWY(NUM_HWY)) u_check (
   .clk(clk), .rst_n(rst_n), .live(live), .bit_pos(bit_pos),
   .frame_end(frame_end), .wr_page(wr_page), .txd(txd), .txoe(txoe)
);

// File: tb/tsi_core_test.sv
module tsi_core_test;
   localparam int NH = 4;
   localparam int NS = 4;
   localparam int EW = 5;
   localparam int AW = 5;
   localparam int DW = 8;
   localparam int FR = NS * 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          fsync;
   logic [NH-1:0] rxd;
   logic [NH-1:0] txd;
   logic [NH-1:0] txoe;
   logic          host_en;
   logic          host_we;
   logic          host_sel;
   logic [AW-1:0] host_addr;
   logic [DW-1:0] host_wdata;
   logic [DW-1:0] host_rdata;

   tsi_core #(.NUM_HWY(NH), .SLOTS(NS)) uut (
      .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd), .txd(txd), .txoe(txoe),
      .host_en(host_en), .host_we(host_we), .host_sel(host_sel),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   always #10 clk = ~clk;

   // Connection map, index h*NS+s: {enable, source highway[1:0], source slot[1:0]}
   localparam logic [EW-1:0] MAP [NH*NS] = '{
      5'b11011, 5'b10000, 5'b00101, 5'b11111,
      5'b10101, 5'b11100, 5'b11010, 5'b10011,
      5'b10011, 5'b00000, 5'b10100, 5'b11011,
      5'b11100, 5'b11101, 5'b10010, 5'b01111
   };

   int checks = 0;
   int fails  = 0;

   function automatic logic [7:0] pat(int fr, int h, int s);
      return 8'(fr * 59 + h * 23 + s * 7 + 17);
   endfunction

   task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic host_write(input logic sel, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b1; host_sel = sel; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_en = 1'b0; host_we = 1'b0;
   endtask

   task automatic host_read(input logic sel, input logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b0; host_sel = sel; host_addr = a;
      @(negedge clk);
      host_en = 1'b0;
      d = host_rdata;
   endtask

   logic [7:0] cap    [NH];
   int         oe_bad [NH];

   // Each negedge: sample the output of the current position, then drive its inputs.
   task automatic run_frames(int n);
      for (int fr = 0; fr < n; fr++) begin
         for (int c = 0; c < FR; c++) begin
            @(negedge clk);
            for (int h = 0; h < NH; h++) begin
               logic [EW-1:0] e;
               logic          exp_oe;
               e      = MAP[h*NS + c/8];
               exp_oe = (fr == 0 && c/8 == 0) ? 1'b0 : e[4];
               cap[h] = {cap[h][6:0], txd[h]};
               if (c % 8 == 0) oe_bad[h] = 0;
               if (txoe[h] !== exp_oe) oe_bad[h]++;
               if (c % 8 == 7) begin
                  int s;
                  int sh;
                  int ss;
                  s  = c / 8;
                  sh = int'(e[3:2]);
                  ss = int'(e[1:0]);
                  if (fr >= 1) begin
                     check((s == 0 && ss == NS-1) ? "R5" : "R2 R3 R4",
                           $sformatf("frame %0d out h%0d s%0d", fr, h, s),
                           16'(cap[h]), e[4] ? 16'(pat(fr-1, sh, ss)) : 16'h00FF);
                     check(e[4] ? "R6/R7" : "R6", $sformatf("oe frame %0d h%0d s%0d", fr, h, s),
                           16'(oe_bad[h]), 16'd0);
                  end else if (s == 0) begin
                     check("R1", $sformatf("no oe in first slot h%0d", h), 16'(oe_bad[h]), 16'd0);
                  end
               end
            end
            fsync = (c == 0);
            for (int h = 0; h < NH; h++) begin
               logic [7:0] b;
               b = pat(fr, h, c / 8);
               rxd[h] = b[7 - (c % 8)];
            end
         end
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] rd;
      rst_n = 1'b0; fsync = 1'b0; rxd = '0;
      host_en = 1'b0; host_we = 1'b0; host_sel = 1'b0; host_addr = '0; host_wdata = '0;
      for (int h = 0; h < NH; h++) begin cap[h] = '0; oe_bad[h] = 0; end
      repeat (3) @(negedge clk);
      check("R1", "txd at reset", 16'(txd), 16'hF);
      check("R1", "txoe at reset", 16'(txoe), 16'h0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      check("R1", "txoe without fsync", 16'(txoe), 16'h0);
      check("R1", "txd without fsync", 16'(txd), 16'hF);

      // Vector table walk: load map, then confirm via read-back
      for (int i = 0; i < NH*NS; i++) host_write(1'b1, AW'(i), DW'(MAP[i]));
      for (int i = 0; i < NH*NS; i += 5) begin
         host_read(1'b1, AW'(i), rd);
         check("R8", $sformatf("conn read %0d", i), 16'(rd), 16'(MAP[i]));
      end

      run_frames(4);
      fsync = 1'b0;
      rxd   = '0;

      // Frame 3 wrote page 1 (pages 0,1,0,1 from first sync); frame 4 now writes page 0.
      host_read(1'b0, AW'(16 + 0*NS + 0), rd);
      check("R8 R3", "data page1 h0 s0", 16'(rd), 16'(pat(3, 0, 0)));
      host_read(1'b0, AW'(16 + 3*NS + 3), rd);
      check("R8 R3", "data page1 h3 s3", 16'(rd), 16'(pat(3, 3, 3)));
      host_read(1'b0, AW'(16 + 2*NS + 1), rd);
      check("R8 R3", "data page1 h2 s1", 16'(rd), 16'(pat(3, 2, 1)));
      host_write(1'b0, AW'(16 + 1*NS + 1), 8'h3C);
      host_read(1'b0, AW'(16 + 1*NS + 1), rd);
      check("R8", "data write readback", 16'(rd), 16'h003C);

      // Asynchronous reset mid-frame
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", "txd after async reset", 16'(txd), 16'hF);
      check("R1", "txoe after async reset", 16'(txoe), 16'h0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (FR + 4) @(negedge clk);
      check("R1", "txoe idle after reset", 16'(txoe), 16'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule